// File: doc/BRIEF.md
# Privileged Processor Status Word

This block holds a 16-bit processor status word made of two bytes. The low byte carries five arithmetic condition flags: carry, half carry, overflow, negative and zero. An ALU result can update any subset of these flags through a per-instruction enable mask. Software can also overwrite the flags in either privilege level.

The high byte carries the operating-mode fields: a system/user privilege bit, a single-step trace enable, a two-bit register bank select and a four-bit task priority. Each field is decoded onto its own output pin. The privilege level filters software writes to this byte. Code in system mode may change every field. Code in user mode may change only the bank select, and its writes leave every other high-byte bit as it was.

Access goes through a byte-wide register port. One select line picks the byte, and separate read and write strobes control the transfer.

Top module: `psw_priv_reg`

## Requirements
- R1: When the asynchronous active-low reset is asserted, the block enters system mode (sys_mode=1) with trace off, bank 0, priority 0 and all five flags cleared.
- R2: With rd_en high and byte_sel=0, rdata returns the low byte with carry at bit 7, half carry at bit 6, overflow at bit 2, negative at bit 1 and zero at bit 0. Bits 5:3 read as zero. With rd_en low, rdata is zero.
- R3: alu_flags and alu_mask are ordered {carry, half carry, overflow, negative, zero} from bit 4 down to bit 0. On a clock edge without a low-byte write, each flag takes its alu_flags bit where its alu_mask bit is set and keeps its value elsewhere.
- R4: If a low-byte write (wr_en=1, byte_sel=0) and a nonzero ALU mask arrive in the same cycle, the flags take the written data and the ALU input is ignored.
- R5: A low-byte write takes effect in both user mode and system mode.
- R6: With rd_en high and byte_sel=1, rdata returns the high byte in either mode. The layout is mode bit at bit 7, trace at bit 6, bank at bits 5:4 and priority at bits 3:0.
- R7: A high-byte write made while sys_mode=1 replaces all four high-byte fields.
- R8: A high-byte write made while sys_mode=0 changes only the bank select. Mode, trace and priority keep their values.
- R9: The privilege check uses the mode bit value from before the write. A user-mode write with bit 7 set does not enter system mode.
- R10: sys_mode, trace_en, bank_sel and task_prio follow the stored high-byte fields, and cond_flags follows the stored flags. Each output changes in the cycle after the edge that wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_sel | input | 1 | 0 selects the flag byte, 1 selects the mode byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| alu_flags | input | 5 | ALU flag results {C, AC, V, N, Z} |
| alu_mask | input | 5 | Per-flag update enables, same order |
| sys_mode | output | 1 | 1 = system mode, 0 = user mode |
| trace_en | output | 1 | Single-step trace enable |
| bank_sel | output | 2 | Active register bank |
| task_prio | output | 4 | Priority of the running task |
| cond_flags | output | 5 | Stored flags {C, AC, V, N, Z} |

## Verification
The block has no parameters, so the bench builds the one fixed layout it defines. The vector walk starts in system mode and hands over to user mode with a system-mode write. That places both privilege levels, the pre-write mode check and the clash between a software write and an ALU update in one sequence, and each step checks both bytes. Directed tests then return to system mode through reset to check the full-field system writes and the idle read value.

// File: rtl/psw_priv_reg.sv
module psw_priv_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [4:0] alu_flags,
  input  logic [4:0] alu_mask,
  output logic       sys_mode,
  output logic       trace_en,
  output logic [1:0] bank_sel,
  output logic [3:0] task_prio,
  output logic [4:0] cond_flags
);

  logic [4:0] flg_q;
  logic       sm_q, tm_q;
  logic [1:0] rs_q;
  logic [3:0] pri_q;

  logic wr_lo, wr_hi;
  logic [7:0] lo_byte, hi_byte;

  assign wr_lo = wr_en && !byte_sel;
  assign wr_hi = wr_en && byte_sel;

  assign lo_byte = {flg_q[4], flg_q[3], 3'b000, flg_q[2], flg_q[1], flg_q[0]};
  assign hi_byte = {sm_q, tm_q, rs_q, pri_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flg_q <= '0;
    else if (wr_lo)
      flg_q <= {wdata[7], wdata[6], wdata[2], wdata[1], wdata[0]};
    else
      flg_q <= (flg_q & ~alu_mask) | (alu_flags & alu_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sm_q  <= 1'b1;
      tm_q  <= 1'b0;
      rs_q  <= '0;
      pri_q <= '0;
    end else if (wr_hi) begin
      rs_q <= wdata[5:4];
      if (sm_q) begin
        sm_q  <= wdata[7];
        tm_q  <= wdata[6];
        pri_q <= wdata[3:0];
      end
    end
  end

  assign rdata      = !rd_en ? 8'h00 : (byte_sel ? hi_byte : lo_byte);
  assign sys_mode   = sm_q;
  assign trace_en   = tm_q;
  assign bank_sel   = rs_q;
  assign task_prio  = pri_q;
  assign cond_flags = flg_q;

endmodule

module psw_priv_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [4:0] alu_flags,
  input logic [4:0] alu_mask,
  input logic       sys_mode,
  input logic       trace_en,
  input logic [1:0] bank_sel,
  input logic [3:0] task_prio,
  input logic [4:0] cond_flags
);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !byte_sel) |-> rdata[5:3] == 3'b000);

  p_idle_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && !byte_sel) && alu_mask == 5'b0) |=> $stable(cond_flags));

  p_sw_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !byte_sel) |=>
      cond_flags == {$past(wdata[7]), $past(wdata[6]), $past(wdata[2]), $past(wdata[1]), $past(wdata[0])});

  p_sys_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && byte_sel && sys_mode) |=>
      {sys_mode, trace_en, bank_sel, task_prio} == $past(wdata));

  p_user_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && byte_sel && !sys_mode) |=>
      $stable(trace_en) && $stable(task_prio) && bank_sel == $past(wdata[5:4]));

  p_no_escalate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_mode |=> !sys_mode);

endmodule

bind psw_priv_reg psw_priv_reg_chk chk_i (.*);

// File: tb/psw_priv_reg_tb_top.sv
module psw_priv_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] alu_flags = '0;
  logic [4:0] alu_mask = '0;
  logic       sys_mode, trace_en;
  logic [1:0] bank_sel;
  logic [3:0] task_prio;
  logic [4:0] cond_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  psw_priv_reg dut_i (.*);

  // {wr, sel, wdata, mask, flags, exp_lo, exp_hi}
  localparam logic [35:0] VEC [10] = '{
    {1'b0, 1'b0, 8'h00, 5'b11111, 5'b10101, 8'h85, 8'h80}, // R3 all flags
    {1'b0, 1'b0, 8'h00, 5'b01010, 5'b01010, 8'hC7, 8'h80}, // R3 subset set
    {1'b0, 1'b0, 8'h00, 5'b10001, 5'b00000, 8'h46, 8'h80}, // R3 subset clear
    {1'b1, 1'b0, 8'hFF, 5'b11111, 5'b00000, 8'hC7, 8'h80}, // R4 sw wins, R2 rsvd
    {1'b1, 1'b0, 8'h00, 5'b00000, 5'b00000, 8'h00, 8'h80}, // R5 sys write low
    {1'b1, 1'b1, 8'h6A, 5'b00000, 5'b00000, 8'h00, 8'h6A}, // R7 drop to user
    {1'b1, 1'b1, 8'hFF, 5'b00000, 5'b00000, 8'h00, 8'h7A}, // R8 bank only
    {1'b1, 1'b1, 8'h80, 5'b00000, 5'b00000, 8'h00, 8'h4A}, // R9 no escalation
    {1'b1, 1'b0, 8'h42, 5'b00000, 5'b00000, 8'h42, 8'h4A}, // R5 user write low
    {1'b0, 1'b0, 8'h00, 5'b00100, 5'b00100, 8'h46, 8'h4A}  // R3 in user mode
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic s, input logic [7:0] d,
                      input logic [4:0] m, input logic [4:0] f);
    @(negedge clk);
    wr_en = w; byte_sel = s; wdata = d; alu_mask = m; alu_flags = f;
    @(posedge clk);
    #1;
    wr_en = 1'b0; alu_mask = '0;
  endtask

  task automatic read_both(output logic [7:0] lo, output logic [7:0] hi);
    rd_en = 1'b1; byte_sel = 1'b0; #1 lo = rdata;
    byte_sel = 1'b1; #1 hi = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    logic [7:0] lo, hi;
    #20;
    read_both(lo, hi);
    chk("R1 lo", lo, 8'h00);
    chk("R1 hi", hi, 8'h80);
    chk("R1 flags", {3'b0, cond_flags}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][35], VEC[i][34], VEC[i][33:26], VEC[i][25:21], VEC[i][20:16]);
      read_both(lo, hi);
      chk($sformatf("R2/R3/R4/R5 lo vec%0d", i), lo, VEC[i][15:8]);
      chk($sformatf("R6/R7/R8/R9 hi vec%0d", i), hi, VEC[i][7:0]);
      chk($sformatf("R10 decode vec%0d", i),
          {sys_mode, trace_en, bank_sel, task_prio}, VEC[i][7:0]);
      chk($sformatf("R10 flags vec%0d", i), {3'b0, cond_flags},
          {3'b0, VEC[i][15], VEC[i][14], VEC[i][10:8]});
    end

    @(negedge clk);
    rst_n = 1'b0;
    #2;
    read_both(lo, hi);
    chk("R1 re-reset lo", lo, 8'h00);
    chk("R1 re-reset hi", hi, 8'h80);
    @(negedge clk);
    rst_n = 1'b1;

    step(1'b1, 1'b1, 8'h9F, 5'b0, 5'b0);
    read_both(lo, hi);
    chk("R7 sys write 9F", hi, 8'h9F);
    chk("R10 prio", {4'b0, task_prio}, 8'h0F);
    step(1'b1, 1'b1, 8'hC3, 5'b0, 5'b0);
    read_both(lo, hi);
    chk("R7 sys write C3", hi, 8'hC3);
    chk("R10 trace", {7'b0, trace_en}, 8'h01);

    step(1'b0, 1'b0, 8'h00, 5'b11111, 5'b11111);
    rd_en = 1'b0; byte_sel = 1'b0; #1;
    chk("R2 idle read", rdata, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule